// File: doc/BRIEF.md
# Addressed Serial Slave Front End

This block is the serial front end of a small multi-channel control device. It listens on a three-wire serial bus (clock, data in, data out, plus an active-low chip select) and turns each framed transfer into parallel byte strobes for a downstream register file. Every frame opens with an 8-bit slave address. The upper six bits must equal a fixed family code, which is set by a parameter. The lower two bits must equal two strap inputs, so up to four devices can share one bus. After the address come an opcode byte, a register address byte and then any number of data bytes.

All bus pins are brought into the system clock domain through a synchronizer and sampled there. Serial input bits are taken on rising serial-clock edges, most significant bit first. Read data is moved onto the serial output on falling edges. A pause input freezes a transfer in place without losing its position. A write-protect input vetoes write requests aimed at non-volatile storage. After reset, the block ignores the bus until chip select has been seen going from high to low.

Top module: `spi_addr_slave`

## Requirements
- R1: Serial input bits are captured on rising `sck` edges, MSB first. After every eighth bit of a selected frame (opcode byte onward), `byte_stb` pulses high for exactly one clock, with `byte_data` holding the byte and `byte_idx` holding its position: 1 = opcode, 2 = register address, 3 and up = data.
- R2: Byte 0 of a frame is the slave address. Bits [7:2] must equal FAMILY_CODE and bits [1:0] must equal `strap`. On a mismatch, no strobe is issued and `so_en` stays low for the rest of that frame.
- R3: In the opcode byte, bit 7 = 1 selects a read and bit 6 = 1 marks a non-volatile target. For a write opcode (bit 7 = 0), every data byte (index 3 and up) also raises `wr_stb` for one clock, with `wr_nv` equal to opcode bit 6. Read frames never raise `wr_stb`.
- R4: While `wp_n` is low, `wr_stb` is suppressed for non-volatile writes. Volatile writes and all `byte_stb` pulses are unaffected.
- R5: In a read frame, starting at the first falling `sck` after the register address byte, `so` carries `rd_data` MSB first and changes only on falling edges. `rd_data` is sampled at the first falling edge of each read byte.
- R6: `so_en` is low out of reset, whenever `cs_n` is high, during a pause, and at all times outside the read phase of a selected read frame.
- R7: After reset, no strobe is produced until `cs_n` has been seen making a high-to-low transition.
- R8: `hold_n` driven low while `sck` is low pauses the transfer, so that `sck` edges are ignored. `hold_n` driven high while `sck` is low resumes it. The bit and byte position is kept across the pause.
- R9: `cs_n` rising mid-byte aborts the frame. The partial byte is discarded and the next frame starts again at the address byte.
- R10: `byte_idx` saturates at 2^IDX_W-1 (15 by default) for long frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sck | input | 1 | Serial clock |
| cs_n | input | 1 | Active-low chip select |
| si | input | 1 | Serial data in |
| hold_n | input | 1 | Active-low pause request |
| wp_n | input | 1 | Active-low write protect for non-volatile writes |
| strap | input | STRAP_W | Device address strap pins |
| rd_data | input | BYTE_W | Read byte from the register file |
| so | output | 1 | Serial data out, high impedance when not enabled |
| so_en | output | 1 | Output enable of `so` |
| byte_stb | output | 1 | One-clock received byte strobe |
| byte_idx | output | IDX_W | Position of the strobed byte in the frame |
| byte_data | output | BYTE_W | Strobed byte value |
| wr_stb | output | 1 | One-clock write request for a data byte |
| wr_nv | output | 1 | Write request targets non-volatile storage |

## Verification
The delicate overlap is a pause that falls inside a read byte. Freezing the bit position and releasing the serial output must happen together, while `sck` keeps toggling on the bus. The bench asserts `hold_n` in the middle of a read byte and of a write byte, then clocks garbage through `sck` during the pause. It requires `so_en` to be low throughout the pause, and requires the read bits and written bytes after resumption to match values computed from the register address. It also drops chip select in the middle of a byte and checks that the following frame decodes from its address byte without any stray strobe.

// File: rtl/spi_slv_pkg.sv
package spi_slv_pkg;

   // decoded opcode flags held for the rest of a frame
   typedef struct packed {
      logic rd;
      logic nv;
   } op_t;

endpackage

// File: rtl/spi_slv_sync.sv
module spi_slv_sync #(
   parameter int W      = 5,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   for (genvar g = 0; g < STAGES; g++) begin : g_stg
      logic [W-1:0] r;
      if (g == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) r <= '0;
            else        r <= d;
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) r <= '0;
            else        r <= g_stg[g-1].r;
      end
   end

   assign q = g_stg[STAGES-1].r;

endmodule

// File: rtl/spi_slv_edge.sv
module spi_slv_edge (
   input  logic clk,
   input  logic rst_n,
   input  logic s_sck,
   input  logic s_cs_n,
   input  logic s_hold_n,
   output logic armed,
   output logic active,
   output logic held,
   output logic sck_rise,
   output logic sck_fall
);

   logic prev_sck;
   logic prev_cs;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_sck <= 1'b0;
         prev_cs  <= 1'b0;   // assume low so a real high-to-low is needed
         armed    <= 1'b0;
         held     <= 1'b0;
      end else begin
         prev_sck <= s_sck;
         prev_cs  <= s_cs_n;
         if (prev_cs && !s_cs_n) armed <= 1'b1;
         if (!active)            held  <= 1'b0;
         else if (!s_sck)        held  <= !s_hold_n;
      end
   end

   assign active   = armed && !s_cs_n;
   assign sck_rise = active && !held &&  s_sck && !prev_sck;
   assign sck_fall = active && !held && !s_sck &&  prev_sck;

endmodule

// File: rtl/spi_slv_shift.sv
module spi_slv_shift #(
   parameter int BYTE_W = 8,
   parameter int IDX_W  = 4
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       active,
   input  logic                       sck_rise,
   input  logic                       si_s,
   output logic                       done,
   output logic [IDX_W-1:0]           dnum,
   output logic [BYTE_W-1:0]          ddat,
   output logic [$clog2(BYTE_W)-1:0]  bit_cnt,
   output logic [IDX_W-1:0]           byte_cnt
);

   localparam int BIT_W = $clog2(BYTE_W);
   localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(BYTE_W - 1);
   localparam logic [IDX_W-1:0] IDX_MAX  = '1;

   logic [BYTE_W-2:0] sh;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         done     <= 1'b0;
         dnum     <= '0;
         ddat     <= '0;
         bit_cnt  <= '0;
         byte_cnt <= '0;
         sh       <= '0;
      end else begin
         done <= 1'b0;
         if (!active) begin
            bit_cnt  <= '0;
            byte_cnt <= '0;
            sh       <= '0;
         end else if (sck_rise) begin
            sh <= {sh[BYTE_W-3:0], si_s};
            if (bit_cnt == LAST_BIT) begin
               bit_cnt <= '0;
               done    <= 1'b1;
               ddat    <= {sh, si_s};
               dnum    <= byte_cnt;
               if (byte_cnt != IDX_MAX) byte_cnt <= byte_cnt + 1'b1;
            end else begin
               bit_cnt <= bit_cnt + 1'b1;
            end
         end
      end
   end

   AST_ABORT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      !active |=> (bit_cnt == '0 && byte_cnt == '0)); // R9

endmodule

// File: rtl/spi_slv_ctrl.sv
module spi_slv_ctrl
   import spi_slv_pkg::*;
#(
   parameter int BYTE_W = 8,
   parameter int IDX_W  = 4,
   parameter int STRAP_W = 2,
   parameter logic [BYTE_W-STRAP_W-1:0] FAM = '0
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       active,
   input  logic                       held,
   input  logic                       sck_fall,
   input  logic                       done,
   input  logic [IDX_W-1:0]           dnum,
   input  logic [BYTE_W-1:0]          ddat,
   input  logic [$clog2(BYTE_W)-1:0]  bit_cnt,
   input  logic [IDX_W-1:0]           byte_cnt,
   input  logic [STRAP_W-1:0]         strap,
   input  logic                       wp_n_s,
   input  logic [BYTE_W-1:0]          rd_data,
   output logic                       byte_stb,
   output logic [IDX_W-1:0]           byte_idx,
   output logic [BYTE_W-1:0]          byte_data,
   output logic                       wr_stb,
   output logic                       wr_nv,
   output logic                       so_bit,
   output logic                       so_en
);

   localparam int RD_BIT = BYTE_W - 1;
   localparam int NV_BIT = BYTE_W - 2;
   localparam logic [IDX_W-1:0] FIRST_DATA = IDX_W'(3);

   logic              sel_q;
   op_t               op_q;
   logic              rd_go;
   logic [BYTE_W-1:0] tx;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel_q     <= 1'b0;
         op_q      <= '0;
         rd_go     <= 1'b0;
         tx        <= '0;
         so_bit    <= 1'b0;
         byte_stb  <= 1'b0;
         byte_idx  <= '0;
         byte_data <= '0;
         wr_stb    <= 1'b0;
         wr_nv     <= 1'b0;
      end else begin
         byte_stb <= 1'b0;
         wr_stb   <= 1'b0;
         if (!active) begin
            sel_q  <= 1'b0;
            op_q   <= '0;
            rd_go  <= 1'b0;
            tx     <= '0;
            so_bit <= 1'b0;
         end else begin
            if (done) begin
               if (dnum == '0) begin
                  sel_q <= (ddat[BYTE_W-1:STRAP_W] == FAM) &&
                           (ddat[STRAP_W-1:0] == strap);
               end else if (sel_q) begin
                  byte_stb  <= 1'b1;
                  byte_idx  <= dnum;
                  byte_data <= ddat;
                  if (dnum == IDX_W'(1))
                     op_q <= '{rd: ddat[RD_BIT], nv: ddat[NV_BIT]};
                  if (dnum >= FIRST_DATA && !op_q.rd && (wp_n_s || !op_q.nv)) begin
                     wr_stb <= 1'b1;
                     wr_nv  <= op_q.nv;
                  end
               end
            end
            if (sck_fall && sel_q && op_q.rd && byte_cnt >= FIRST_DATA) begin
               rd_go <= 1'b1;
               if (bit_cnt == '0) begin
                  so_bit <= rd_data[BYTE_W-1];
                  tx     <= rd_data << 1;
               end else begin
                  so_bit <= tx[BYTE_W-1];
                  tx     <= tx << 1;
               end
            end
         end
      end
   end

   assign so_en = rd_go && active && !held;

   AST_STB_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      byte_stb |=> !byte_stb); // R1
   AST_WP_VETO: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_stb && wr_nv) |-> $past(wp_n_s)); // R4
   AST_OE_READ_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
      so_en |-> (sel_q && op_q.rd)); // R6

endmodule

// File: rtl/spi_addr_slave.sv
module spi_addr_slave
   import spi_slv_pkg::*;
#(
   parameter int          BYTE_W      = 8,
   parameter int          STRAP_W     = 2,
   parameter int          IDX_W       = 4,
   parameter int          SYNC_STAGES = 2,
   parameter int unsigned FAMILY_CODE = 32'h29
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               sck,
   input  logic               cs_n,
   input  logic               si,
   input  logic               hold_n,
   input  logic               wp_n,
   input  logic [STRAP_W-1:0] strap,
   input  logic [BYTE_W-1:0]  rd_data,
   output logic               so,
   output logic               so_en,
   output logic               byte_stb,
   output logic [IDX_W-1:0]   byte_idx,
   output logic [BYTE_W-1:0]  byte_data,
   output logic               wr_stb,
   output logic               wr_nv
);

   localparam int FAM_W = BYTE_W - STRAP_W;
   localparam int BIT_W = $clog2(BYTE_W);
   localparam logic [FAM_W-1:0] FAM = FAM_W'(FAMILY_CODE);

   if (SYNC_STAGES < 2) begin : g_chk_sync
      $error("SYNC_STAGES must be at least 2");
   end
   if (BYTE_W < 4 || BYTE_W != (1 << BIT_W)) begin : g_chk_byte
      $error("BYTE_W must be a power of two of at least 4");
   end
   if (STRAP_W < 1 || STRAP_W > BYTE_W - 3) begin : g_chk_strap
      $error("STRAP_W out of range");
   end
   if (IDX_W < 2) begin : g_chk_idx
      $error("IDX_W must be at least 2");
   end
   if (FAMILY_CODE >= (32'd1 << FAM_W)) begin : g_chk_fam
      $error("FAMILY_CODE does not fit the family field");
   end

   logic s_sck, s_cs_n, s_si, s_hold_n, s_wp_n;
   logic armed, active, held, sck_rise, sck_fall;
   logic done;
   logic [IDX_W-1:0]  dnum, byte_cnt;
   logic [BYTE_W-1:0] ddat;
   logic [BIT_W-1:0]  bit_cnt;
   logic              so_bit;

   spi_slv_sync #(.W(5), .STAGES(SYNC_STAGES)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .d    ({sck, cs_n, si, hold_n, wp_n}),
      .q    ({s_sck, s_cs_n, s_si, s_hold_n, s_wp_n})
   );

   spi_slv_edge u_edge (
      .clk     (clk),
      .rst_n   (rst_n),
      .s_sck   (s_sck),
      .s_cs_n  (s_cs_n),
      .s_hold_n(s_hold_n),
      .armed   (armed),
      .active  (active),
      .held    (held),
      .sck_rise(sck_rise),
      .sck_fall(sck_fall)
   );

   spi_slv_shift #(.BYTE_W(BYTE_W), .IDX_W(IDX_W)) u_shift (
      .clk     (clk),
      .rst_n   (rst_n),
      .active  (active),
      .sck_rise(sck_rise),
      .si_s    (s_si),
      .done    (done),
      .dnum    (dnum),
      .ddat    (ddat),
      .bit_cnt (bit_cnt),
      .byte_cnt(byte_cnt)
   );

   spi_slv_ctrl #(.BYTE_W(BYTE_W), .IDX_W(IDX_W), .STRAP_W(STRAP_W), .FAM(FAM)) u_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .active   (active),
      .held     (held),
      .sck_fall (sck_fall),
      .done     (done),
      .dnum     (dnum),
      .ddat     (ddat),
      .bit_cnt  (bit_cnt),
      .byte_cnt (byte_cnt),
      .strap    (strap),
      .wp_n_s   (s_wp_n),
      .rd_data  (rd_data),
      .byte_stb (byte_stb),
      .byte_idx (byte_idx),
      .byte_data(byte_data),
      .wr_stb   (wr_stb),
      .wr_nv    (wr_nv),
      .so_bit   (so_bit),
      .so_en    (so_en)
   );

   assign so = so_en ? so_bit : 1'bz;

   AST_LOCKOUT: assert property (@(posedge clk) disable iff (!rst_n)
      !armed |-> !done); // R7
   AST_HOLD_KEEPS_POS: assert property (@(posedge clk) disable iff (!rst_n)
      (held && active) |=> $stable(bit_cnt)); // R8

endmodule

// File: tb/tb_spi_addr_slave.sv
module tb_spi_addr_slave;

   localparam int CLK_PERIOD = 10;
   localparam int HALF       = 6;
   localparam logic [7:0] ADDR_BASE = 8'hA4;   // family 6'h29 in bits [7:2]

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       sck = 1'b0, cs_n = 1'b0, si = 1'b0, hold_n = 1'b1, wp_n = 1'b1;
   logic [1:0] strap = 2'd2;
   logic [7:0] rd_data;
   logic       so, so_en, byte_stb, wr_stb, wr_nv;
   logic [3:0] byte_idx;
   logic [7:0] byte_data;

   int checks = 0, fails = 0;
   bit finished = 0;

   int         cap_n = 0;
   int         cap_idx [32];
   logic [7:0] cap_dat [32];
   int         n_wr = 0;
   logic       last_nv = 0;
   logic [7:0] rd_reg = 0, rd_cnt = 0;

   logic [7:0] tx_buf [20];
   logic [7:0] rx_buf [20];
   logic       en_buf [20];

   assign rd_data = (rd_reg ^ 8'h5A) + rd_cnt;

   always #(CLK_PERIOD/2) clk = ~clk;

   spi_addr_slave #(.FAMILY_CODE(32'h29)) dut (
      .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .si(si), .hold_n(hold_n),
      .wp_n(wp_n), .strap(strap), .rd_data(rd_data), .so(so), .so_en(so_en),
      .byte_stb(byte_stb), .byte_idx(byte_idx), .byte_data(byte_data),
      .wr_stb(wr_stb), .wr_nv(wr_nv)
   );

   // register-file model and strobe recorder
   always @(negedge clk) if (rst_n) begin
      if (byte_stb) begin
         if (cap_n < 32) begin
            cap_idx[cap_n] = int'(byte_idx);
            cap_dat[cap_n] = byte_data;
         end
         cap_n++;
         if (byte_idx == 4'd2) begin rd_reg = byte_data; rd_cnt = 0; end
         else if (byte_idx >= 4'd3) rd_cnt++;
      end
      if (wr_stb) begin n_wr++; last_nv = wr_nv; end
   end

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic bit_x(input logic b, output logic sv, output logic ev);
      si = b;
      tick(HALF);
      sv = so; ev = so_en;
      sck = 1'b1;
      tick(HALF);
      sck = 1'b0;
   endtask

   task automatic do_hold();
      hold_n = 1'b0;
      tick(HALF);
      chk(so_en == 1'b0, "R8 R6 so_en during pause", int'(so_en), 0);
      for (int t = 0; t < 3; t++) begin
         si = ~si; sck = 1'b1; tick(HALF);
         sck = 1'b0; tick(HALF);
      end
      hold_n = 1'b1;
      tick(HALF);
   endtask

   task automatic byte_x(input logic [7:0] tb, input int hold_at,
                         output logic [7:0] rb, output logic eb);
      logic sv, ev;
      eb = 1'b0;
      for (int i = 7; i >= 0; i--) begin
         if (i == hold_at) do_hold();
         bit_x(tb[i], sv, ev);
         rb[i] = sv;
         eb = eb | ev;
      end
   endtask

   task automatic run_frame(input int n, input int hb, input int hbit, input bit do_cs);
      logic [7:0] r;
      logic e;
      if (do_cs) cs_n = 1'b0;
      cap_n = 0;
      tick(HALF);
      for (int k = 0; k < n; k++) begin
         byte_x(tx_buf[k], (k == hb) ? hbit : -1, r, e);
         rx_buf[k] = r;
         en_buf[k] = e;
      end
      tick(HALF);
      cs_n = 1'b1;
      tick(4*HALF);
   endtask

   task automatic chk_strobes(input int n, input string tag);
      chk(cap_n == n-1, {tag, " strobe count"}, cap_n, n-1);
      for (int k = 1; k < n && k <= 32; k++) begin
         chk(cap_idx[k-1] == ((k > 15) ? 15 : k), {tag, " byte_idx"}, cap_idx[k-1], (k > 15) ? 15 : k);
         chk(cap_dat[k-1] == tx_buf[k], {tag, " byte_data"}, int'(cap_dat[k-1]), int'(tx_buf[k]));
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         checks++; fails++;
         $display("FAIL watchdog: actual 1 expected 0");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin
      int w0;
      logic [7:0] e;
      tick(4);
      rst_n = 1'b1;
      tick(4);
      // reset state
      chk(so_en == 1'b0, "R6 so_en after reset", int'(so_en), 0);
      chk(byte_stb == 1'b0, "R1 byte_stb after reset", int'(byte_stb), 0);

      // R7: cs_n low since reset, no falling edge seen yet
      tx_buf[0] = ADDR_BASE | 8'd2; tx_buf[1] = 8'h00; tx_buf[2] = 8'h11; tx_buf[3] = 8'h22;
      w0 = n_wr;
      run_frame(4, -1, -1, 1'b0);
      chk(cap_n == 0, "R7 strobes before first cs fall", cap_n, 0);
      chk(n_wr == w0, "R7 writes before first cs fall", n_wr - w0, 0);

      // R1 R2 R3: strap versus address sweep, write opcode
      for (int s = 0; s < 4; s++) begin
         for (int a = 0; a < 4; a++) begin
            strap = 2'(s);
            tx_buf[0] = ADDR_BASE | 8'(a);
            tx_buf[1] = 8'h00;
            tx_buf[2] = 8'h10 + 8'(s*4 + a);
            tx_buf[3] = 8'hC3 ^ 8'(s*16 + a);
            w0 = n_wr;
            run_frame(4, -1, -1, 1'b1);
            if (s == a) begin
               chk_strobes(4, "R1 R2 matched");
               chk(n_wr - w0 == 1, "R3 volatile write", n_wr - w0, 1);
               chk(last_nv == 1'b0, "R3 wr_nv volatile", int'(last_nv), 0);
            end else begin
               chk(cap_n == 0, "R2 strap mismatch", cap_n, 0);
               chk(n_wr == w0, "R2 no write on mismatch", n_wr - w0, 0);
            end
            chk(en_buf[3] == 1'b0, "R6 so_en in write frame", int'(en_buf[3]), 0);
         end
      end
      strap = 2'd1;
      tx_buf[0] = 8'h24 | 8'd1;   // wrong family, right strap
      run_frame(4, -1, -1, 1'b1);
      chk(cap_n == 0, "R2 family mismatch", cap_n, 0);
      tx_buf[0] = ADDR_BASE | 8'd3; tx_buf[1] = 8'h80; tx_buf[2] = 8'h05; tx_buf[3] = 8'h00;
      run_frame(4, -1, -1, 1'b1);
      chk(en_buf[3] == 1'b0, "R2 R6 read to other device", int'(en_buf[3]), 0);

      // R3 R4: write-protect against volatile and non-volatile writes
      for (int wp = 0; wp < 2; wp++) begin
         for (int nv = 0; nv < 2; nv++) begin
            wp_n = wp[0];
            tx_buf[0] = ADDR_BASE | 8'd1;
            tx_buf[1] = nv[0] ? 8'h40 : 8'h00;
            tx_buf[2] = 8'h20;
            tx_buf[3] = 8'h5E + 8'(wp*2 + nv);
            tx_buf[4] = 8'hA1;
            tick(4*HALF);
            w0 = n_wr;
            run_frame(5, -1, -1, 1'b1);
            chk_strobes(5, "R4 strobes kept");
            chk(n_wr - w0 == ((wp == 0 && nv == 1) ? 0 : 2), "R4 write requests",
                n_wr - w0, (wp == 0 && nv == 1) ? 0 : 2);
            if (!(wp == 0 && nv == 1))
               chk(last_nv == nv[0], "R3 wr_nv follows opcode", int'(last_nv), nv);
         end
      end
      wp_n = 1'b1;

      // R5 R6: read frame, two read bytes
      tx_buf[0] = ADDR_BASE | 8'd1; tx_buf[1] = 8'h80; tx_buf[2] = 8'h3C;
      tx_buf[3] = 8'h00; tx_buf[4] = 8'h00;
      w0 = n_wr;
      run_frame(5, -1, -1, 1'b1);
      e = 8'h3C ^ 8'h5A;
      chk(rx_buf[3] == e, "R5 first read byte", int'(rx_buf[3]), int'(e));
      chk(rx_buf[4] == e + 8'd1, "R5 second read byte", int'(rx_buf[4]), int'(e + 8'd1));
      for (int k = 0; k < 3; k++)
         chk(en_buf[k] == 1'b0, "R6 so_en before read phase", int'(en_buf[k]), 0);
      chk(en_buf[3] == 1'b1, "R5 so_en in read phase", int'(en_buf[3]), 1);
      chk(n_wr == w0, "R3 no write in read frame", n_wr - w0, 0);
      chk(so_en == 1'b0, "R6 so_en with cs_n high", int'(so_en), 0);

      // R8: pause inside a read byte
      tx_buf[2] = 8'h71;
      run_frame(5, 3, 4, 1'b1);
      e = 8'h71 ^ 8'h5A;
      chk(rx_buf[3] == e, "R8 read byte across pause", int'(rx_buf[3]), int'(e));
      chk(rx_buf[4] == e + 8'd1, "R8 read after pause", int'(rx_buf[4]), int'(e + 8'd1));

      // R8: pause inside a written data byte
      tx_buf[1] = 8'h00; tx_buf[2] = 8'h33; tx_buf[3] = 8'h96;
      run_frame(4, 3, 5, 1'b1);
      chk_strobes(4, "R8 write across pause");

      // R9: abort after four bits, then a clean frame
      begin
         logic sv, ev;
         cs_n = 1'b0; cap_n = 0; tick(HALF);
         for (int i = 0; i < 4; i++) bit_x(1'b1, sv, ev);
         tick(HALF); cs_n = 1'b1; tick(4*HALF);
         chk(cap_n == 0, "R9 partial byte discarded", cap_n, 0);
      end
      tx_buf[0] = ADDR_BASE | 8'd1; tx_buf[1] = 8'h00; tx_buf[2] = 8'h44; tx_buf[3] = 8'h0F;
      run_frame(4, -1, -1, 1'b1);
      chk_strobes(4, "R9 frame after abort");

      // R10: long frame, index saturation
      tx_buf[0] = ADDR_BASE | 8'd1; tx_buf[1] = 8'h00; tx_buf[2] = 8'h01;
      for (int k = 3; k < 18; k++) tx_buf[k] = 8'(k * 17);
      run_frame(18, -1, -1, 1'b1);
      chk_strobes(18, "R10 saturating index");

      finished = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

endmodule